// File: doc/BRIEF.md
# Clock Fanout Enable Slave

This block is the control side of an 18-way clock fanout. A host on a two-wire serial bus sends it block writes. The block oversamples the bus on its own system clock and acknowledges only its own device address. It receives the command byte and the count byte and then ignores their values. The data bytes that follow fill a small bank of enable registers, always starting from register 0 and moving upward. A stop may end the write after any complete byte. Bytes beyond the last register are acknowledged and then dropped.

Each enable bit gates one clock output. When the global output enable is low, every output is switched off; the high-impedance state is shown as a per-output drive-enable of 0. When the global enable is high, an output with a clear enable bit is held low, and an output with a set enable bit follows the reference clock. A new enable value moves into the gating stage only on a system-clock edge that sees the reference clock low, so no output can produce a runt pulse. While the power-down input is high, the serial port is deaf and the stored enables are kept.

Top module: `clkfan_cfg`

## Requirements
- R1: A transfer is accepted only when the first byte after a start is 0xD2: address 1101001 sent MSB first, then a direction bit of 0. Any other first byte is not acknowledged, and the rest of that transfer is ignored. This includes a read direction (0xD3) and the general call (0x00).
- R2: Bits are taken MSB first on rising SCL. For every accepted byte, `sda_pull_o` is 1 from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock. At all other times the block leaves SDA released.
- R3: The second and third bytes of an accepted transfer (command and count) are acknowledged, and their values have no effect on any output.
- R4: Data byte k (k = 0, 1, 2) is written to register k. Bit j of register k enables output 8k+j. Only bits 0 and 1 of register 2 exist.
- R5: A stop in the middle of a byte discards that byte. Registers written earlier in the same transfer keep their new values.
- R6: Data bytes after the third are acknowledged and change no state.
- R7: While `oe_i` is 0, every bit of `clk_drv_en_o` and `clk_o` is 0. While `oe_i` is 1, every bit of `clk_drv_en_o` is 1.
- R8: While `oe_i` is 1, an output whose active enable is 0 stays low, and an output whose active enable is 1 equals `ref_clk_i`.
- R9: After reset, all 18 enables are 1.
- R10: The active enables take the register values only on a `clk_i` edge at which `ref_clk_i` is 0. Such an edge makes the new value active. While `ref_clk_i` stays high, the outputs keep their old enables.
- R11: While `pwrdn_i` is 1, the serial port gives no acknowledge and writes nothing. The stored enables are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (wired value) |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| pwrdn_i | input | 1 | Power-down: serial port ignored, state kept |
| oe_i | input | 1 | Global output enable |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| clk_o | output | 18 | Gated clock outputs |
| clk_drv_en_o | output | 18 | Per-output driver enable (0 = high impedance) |

## Verification
Two things can land close together: a register write arriving from the serial port, and the gating stage taking in new enables while the reference clock is low. The bench keeps the reference clock high for the whole of each write. It then checks that the outputs keep their old enables, and only afterwards drops the reference clock low. A behavioural model in the bench records the expected register values from the bytes sent. Whenever the model samples the reference clock low, it copies those values into its own active enables. On every clock it compares both output vectors against this model. The acknowledge is judged in the middle of each ninth SCL high phase.

// File: rtl/clkfan_cfg_pkg.sv
package clkfan_cfg_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BITS = 2'd1,
    RX_ACK  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s      = scl_sh[STAGES-1];
  assign sda_s      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign sda_o      = sda_s;
  // data edges while clock stays high mark frame boundaries
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_block_rx.sv
module cfg_block_rx
  import clkfan_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b1101001,
  parameter int unsigned NREG     = 3,
  localparam int unsigned IDXW    = $clog2(NREG + 4),
  localparam int unsigned SLOTW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [SLOTW-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [IDXW-1:0] IDX_MAX   = IDXW'(NREG + 3);
  localparam logic [IDXW-1:0] IDX_DATA0 = IDXW'(3);

  rx_state_e         st_q;
  logic [3:0]        bit_cnt_q;
  logic [IDXW-1:0]   idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              pull_q;
  logic              wr_en_q;
  logic [SLOTW-1:0]  wr_idx_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic [IDXW-1:0]   slot;

  assign slot = idx_q - IDX_DATA0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      pull_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (pwrdn_i) begin
        st_q   <= RX_IDLE;
        pull_q <= 1'b0;
      end else if (start_i) begin
        st_q      <= RX_BITS;
        bit_cnt_q <= '0;
        idx_q     <= '0;
        pull_q    <= 1'b0;
      end else if (stop_i) begin
        st_q   <= RX_IDLE;
        pull_q <= 1'b0;
      end else begin
        unique case (st_q)
          RX_BITS: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              sh_q      <= {sh_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              if (idx_q == '0 && sh_q != {DEV_ADDR, 1'b0}) begin
                st_q <= RX_IDLE;
              end else begin
                pull_q <= 1'b1;
                st_q   <= RX_ACK;
                if (idx_q >= IDX_DATA0 && slot < IDXW'(NREG)) begin
                  wr_en_q   <= 1'b1;
                  wr_idx_q  <= slot[SLOTW-1:0];
                  wr_data_q <= sh_q;
                end
              end
            end
          end
          RX_ACK: begin
            if (scl_fall_i) begin
              pull_q    <= 1'b0;
              bit_cnt_q <= '0;
              st_q      <= RX_BITS;
              if (idx_q != IDX_MAX) idx_q <= idx_q + IDXW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_en_o    = wr_en_q;
  assign wr_idx_o   = wr_idx_q;
  assign wr_data_o  = wr_data_q;

  p_ack_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> $past(scl_fall_i));
  p_stop_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pull_q);
  p_pwrdn_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> (!pull_q && !wr_en_q));
endmodule

// File: rtl/cfg_enable_bank.sv
module cfg_enable_bank
  import clkfan_cfg_pkg::*;
#(
  parameter int unsigned NUM_OUT = 18,
  localparam int unsigned NREG   = (NUM_OUT + BYTE_W - 1) / BYTE_W,
  localparam int unsigned SLOTW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SLOTW-1:0]   wr_idx_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  output logic [NUM_OUT-1:0] en_o
);
  logic [NUM_OUT-1:0] en_q;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[i] <= 1'b1;
      else if (wr_en_i && wr_idx_i == SLOTW'(i / BYTE_W))
        en_q[i] <= wr_data_i[i % BYTE_W];
    end
  end

  assign en_o = en_q;

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q));
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int unsigned NUM_OUT = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               oe_i,
  input  logic [NUM_OUT-1:0] en_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] drv_en_o
);
  logic [NUM_OUT-1:0] act_q;

  // enables move only while the reference is low: no runt pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         act_q <= '1;
    else if (!ref_clk_i) act_q <= en_i;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign clk_o[i]    = oe_i & act_q[i] & ref_clk_i;
    assign drv_en_o[i] = oe_i;
  end

  p_act_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_clk_i |=> $stable(act_q));
endmodule

// File: rtl/clkfan_cfg.sv
module clkfan_cfg
  import clkfan_cfg_pkg::*;
#(
  parameter int unsigned NUM_OUT  = 18,
  parameter logic [6:0]  DEV_ADDR = 7'b1101001,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic               pwrdn_i,
  input  logic               oe_i,
  input  logic               ref_clk_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_drv_en_o
);
  localparam int unsigned NREG  = (NUM_OUT + BYTE_W - 1) / BYTE_W;
  localparam int unsigned SLOTW = (NREG > 1) ? $clog2(NREG) : 1;

  logic scl_rise, scl_fall, sda_s, start_p, stop_p;
  logic wr_en;
  logic [SLOTW-1:0]   wr_idx;
  logic [BYTE_W-1:0]  wr_data;
  logic [NUM_OUT-1:0] en;

  cfg_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .sda_o(sda_s),
    .start_o(start_p), .stop_o(stop_p)
  );

  cfg_block_rx #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwrdn_i(pwrdn_i),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start_p), .stop_i(stop_p), .sda_pull_o(sda_pull_o),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  cfg_enable_bank #(.NUM_OUT(NUM_OUT)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .en_o(en)
  );

  clk_gate_bank #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i), .oe_i(oe_i),
    .en_i(en), .clk_o(clk_o), .drv_en_o(clk_drv_en_o)
  );
endmodule

// File: tb/clkfan_cfg_bench.sv
`timescale 1ns/1ps
module clkfan_cfg_bench;
  localparam int N  = 18;
  localparam int QP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1, pd = 1'b0, oe = 1'b1, refc = 1'b0;
  logic sda_pull, sda_line;
  logic [N-1:0] clk_out, drv_en;
  logic [N-1:0] exp_cfg, exp_act;
  int n_tests = 0, n_fail = 0;
  bit chk_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_h & ~sda_pull;

  clkfan_cfg u_clkfan_cfg (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .pwrdn_i(pd), .oe_i(oe), .ref_clk_i(refc),
    .clk_o(clk_out), .clk_drv_en_o(drv_en)
  );

  // reference model of the gating stage (R7, R8, R10)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) exp_act <= '1;
    else if (!refc) exp_act <= exp_cfg;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on && !done) begin
    chk(clk_out == ((oe && refc) ? exp_act : '0), "R8/R10 per-cycle clk_o", 32'(clk_out),
        32'((oe && refc) ? exp_act : '0));
    chk(drv_en == (oe ? {N{1'b1}} : {N{1'b0}}), "R7 per-cycle drv_en", 32'(drv_en),
        32'(oe ? {N{1'b1}} : {N{1'b0}}));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ref_run(input int n);
    for (int i = 0; i < n; i++) begin refc = ~refc; cyc(2); end
    refc = 1'b1; cyc(2);
  endtask

  task automatic s_start();
    sda_h = 1'b1; scl_h = 1'b1; cyc(QP);
    sda_h = 1'b0; cyc(QP);
    scl_h = 1'b0; cyc(QP);
  endtask

  task automatic s_stop();
    sda_h = 1'b0; cyc(QP);
    scl_h = 1'b1; cyc(QP);
    sda_h = 1'b1; cyc(QP);
  endtask

  task automatic s_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_h = b[i]; cyc(QP);
      scl_h = 1'b1; cyc(QP);
      if (b[i]) chk(sda_line == 1'b1, "R2 released during data", 32'(sda_line), 1);
      cyc(QP);
      scl_h = 1'b0; cyc(QP);
    end
  endtask

  task automatic s_byte(input logic [7:0] b, input logic exp_ack, input string req);
    s_bits(b, 8);
    sda_h = 1'b1; cyc(QP);
    scl_h = 1'b1; cyc(QP);
    chk(sda_pull == exp_ack, req, 32'(sda_pull), 32'(exp_ack));
    cyc(QP);
    scl_h = 1'b0; cyc(QP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    exp_cfg = '1;
    cyc(4);
    rst_n = 1'b1; chk_on = 1'b1; cyc(2);
    // R9 reset state
    chk(clk_out == '0 && drv_en == '1, "R9 reset, ref low", 32'(clk_out), 0);
    ref_run(4);
    chk(clk_out == {N{1'b1}}, "R9 all enabled after reset", 32'(clk_out), 32'({N{1'b1}}));

    // R1, R3, R4: full write, MSB first
    s_start();
    s_byte(8'hD2, 1'b1, "R1 own address ack");
    s_byte(8'h5A, 1'b1, "R3 command ack");
    s_byte(8'h07, 1'b1, "R3 count ack");
    s_byte(8'h0F, 1'b1, "R2 data0 ack"); exp_cfg[7:0] = 8'h0F;
    s_byte(8'hA5, 1'b1, "R4 data1 ack"); exp_cfg[15:8] = 8'hA5;
    s_byte(8'h02, 1'b1, "R4 data2 ack"); exp_cfg[17:16] = 2'b10;
    s_stop();
    chk(clk_out == {N{1'b1}}, "R10 old enables while ref high", 32'(clk_out), 32'({N{1'b1}}));
    ref_run(4);
    chk(clk_out == 18'h2A50F, "R4 mapping byte k bit j", 32'(clk_out), 32'h2A50F);

    // R1 address rejects
    s_start();
    s_byte(8'hD4, 1'b0, "R1 wrong address nack");
    s_byte(8'h00, 1'b0, "R1 ignored after mismatch");
    s_stop();
    s_start(); s_byte(8'hD3, 1'b0, "R1 read direction nack"); s_stop();
    s_start(); s_byte(8'h00, 1'b0, "R1 general call nack"); s_byte(8'h00, 1'b0, "R1 general call ignored"); s_stop();
    ref_run(4);
    chk(clk_out == 18'h2A50F, "R1 rejected writes no effect", 32'(clk_out), 32'h2A50F);

    // R5 stop mid-byte
    s_start();
    s_byte(8'hD2, 1'b1, "R5 addr ack");
    s_byte(8'h00, 1'b1, "R3 cmd ack");
    s_byte(8'h20, 1'b1, "R3 count ack");
    s_byte(8'hFF, 1'b1, "R5 data0 ack"); exp_cfg[7:0] = 8'hFF;
    s_bits(8'h00, 4);
    s_stop();
    ref_run(4);
    chk(clk_out == 18'h2A5FF, "R5 partial byte dropped", 32'(clk_out), 32'h2A5FF);

    // R6 excess bytes
    s_start();
    s_byte(8'hD2, 1'b1, "R6 addr ack");
    s_byte(8'h00, 1'b1, "R6 cmd ack");
    s_byte(8'h05, 1'b1, "R6 count ack");
    s_byte(8'h11, 1'b1, "R6 data0 ack");
    s_byte(8'h22, 1'b1, "R6 data1 ack");
    s_byte(8'h03, 1'b1, "R6 data2 ack");
    exp_cfg = 18'h32211;
    s_byte(8'h00, 1'b1, "R6 extra byte ack");
    s_byte(8'h00, 1'b1, "R6 extra byte ack 2");
    s_stop();
    ref_run(4);
    chk(clk_out == 18'h32211, "R6 extra bytes dropped", 32'(clk_out), 32'h32211);

    // R7 global enable off
    oe = 1'b0; cyc(2);
    chk(clk_out == '0 && drv_en == '0, "R7 oe low all off", 32'(drv_en), 0);
    ref_run(4);
    oe = 1'b1; cyc(2);
    chk(drv_en == {N{1'b1}}, "R7 oe high drivers on", 32'(drv_en), 32'({N{1'b1}}));

    // R11 power-down
    pd = 1'b1; cyc(2);
    s_start();
    s_byte(8'hD2, 1'b0, "R11 no ack in power-down");
    s_byte(8'h00, 1'b0, "R11 no ack cmd");
    s_byte(8'h01, 1'b0, "R11 no ack count");
    s_byte(8'h00, 1'b0, "R11 no ack data");
    s_stop();
    pd = 1'b0; cyc(2);
    ref_run(4);
    chk(clk_out == 18'h32211, "R11 config retained", 32'(clk_out), 32'h32211);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule